// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This peripheral gives a CPU three 8-bit parallel ports (A, B and C) and one control register. A two-bit address, an active-low chip select and active-low read and write strobes select the target. Every port pin is modelled as three parts: an input bit, a latched output bit and an output-enable bit. Ports A and B each have one direction for all eight bits. Port C has a separate direction for its upper nibble and for its lower nibble. The upper nibble of C belongs with Port A as group A. The lower nibble of C belongs with Port B as group B.

Software uses the control register address in two ways, and bit 7 of the written word decides which. A word with bit 7 high is a configuration word. It sets the direction of all four port sections in basic mode and clears every output latch. A word with bit 7 low is a single-bit command that forces one Port C output latch bit high or low, and it leaves the configuration alone. Output data is held in latches. Input data passes straight from the pins to the read bus without being latched.

Writes take effect at the rising clock edge on which chip select and the write strobe are both low. Reads are combinational while chip select and the read strobe are both low.

Top module: `parPortCtl`

## Requirements
- R1: During and after reset, every output-enable bit is 0 (all ports are inputs) and every output latch is 0.
- R2: Address 0 selects Port A, 1 selects Port B, 2 selects Port C and 3 selects the control register. A read of address 3 returns 0xFF.
- R3: A control write with bit 7 = 1 and bits 6-5 and bit 2 all zero sets the directions as follows: bit 4 for Port A, bit 3 for C[7:4], bit 1 for Port B and bit 0 for C[3:0]. A 1 means input and a 0 means output. Each output-enable bit equals the inverse of its section's input bit. The word 0x9B makes every section an input.
- R4: An accepted configuration word (R3) clears all three output latches to 0 on the same edge.
- R5: A configuration word with a nonzero value in bits 6-5 or in bit 2 requests a reserved mode. It is ignored: directions and latches stay unchanged.
- R6: A control write with bit 7 = 0 loads bit 0 into Port C latch bit [3:1]. Bits 6-4 are ignored, and the other latch bits are unchanged. For example, 0x09 sets C bit 4.
- R7: A single-bit command (R6) leaves every output-enable bit unchanged.
- R8: A read of a port section configured as output returns its latch. A read of a section configured as input returns the live pin value in the same cycle.
- R9: A read of Port C combines its two nibbles, each according to its own direction.
- R10: A write to address 0, 1 or 2 loads that port's latch. The new value drives the port's output bus after that clock edge.
- R11: With chip select high, writes have no effect. When no read is in progress (chip select or read strobe high), the read bus is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| wrData | input | 8 | CPU write data |
| rdData | output | 8 | CPU read data |
| portAIn | input | 8 | Port A pin input |
| portAOut | output | 8 | Port A output latch |
| portAOe | output | 8 | Port A output enable |
| portBIn | input | 8 | Port B pin input |
| portBOut | output | 8 | Port B output latch |
| portBOe | output | 8 | Port B output enable |
| portCIn | input | 8 | Port C pin input |
| portCOut | output | 8 | Port C output latch |
| portCOe | output | 8 | Port C output enable |

## Verification
A wrong direction bit shows up in two places on the cycle after the control write. The output-enable bus of the affected section changes, and reads of that section return latch data instead of pin data, or pin data instead of latch data. A latch that is corrupted, for example a single-bit command that hits the wrong index or a configuration word that fails to clear, shows on the port's output bus one edge after the write. It shows again on any read of that section while it is an output. The bench compares every output bus and every read against a model after each access, so a fault is reported within one bus cycle.

// File: rtl/parPortPkg.sv
package parPortPkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int ADDR_W = 2;

  typedef struct packed {
    logic              wrA;
    logic              wrB;
    logic              wrC;
    logic              clrAll;
    logic              bitOp;
    logic [IDX_W-1:0]  bitIdx;
    logic              bitVal;
  } portStrobe_t;

  typedef struct packed {
    logic inA;
    logic inCu;
    logic inB;
    logic inCl;
  } portDir_t;
endpackage

// File: rtl/parPortCtrl.sv
module parPortCtrl
  import parPortPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output portStrobe_t       strobe,
  output portDir_t          dir
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(3);

  logic wrEn, ctrlWr, modeWr, reservedMode, acceptMode;

  assign wrEn         = !csN && !wrN;
  assign ctrlWr       = wrEn && (addr == CTRL_ADDR);
  assign modeWr       = ctrlWr && wrData[7];
  assign reservedMode = (wrData[6:5] != 2'b00) || wrData[2];
  assign acceptMode   = modeWr && !reservedMode;

  always_comb begin
    strobe        = '0;
    strobe.wrA    = wrEn && (addr == ADDR_W'(0));
    strobe.wrB    = wrEn && (addr == ADDR_W'(1));
    strobe.wrC    = wrEn && (addr == ADDR_W'(2));
    strobe.clrAll = acceptMode;
    strobe.bitOp  = ctrlWr && !wrData[7];
    strobe.bitIdx = wrData[IDX_W:1];
    strobe.bitVal = wrData[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dir <= '{inA: 1'b1, inCu: 1'b1, inB: 1'b1, inCl: 1'b1};
    end else if (acceptMode) begin
      dir.inA  <= wrData[4];
      dir.inCu <= wrData[3];
      dir.inB  <= wrData[1];
      dir.inCl <= wrData[0];
    end
  end
endmodule

// File: rtl/parPortData.sv
module parPortData
  import parPortPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strobe,
  input  portDir_t          dir,
  input  logic              csN,
  input  logic              rdN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] portAIn,
  input  logic [DATA_W-1:0] portBIn,
  input  logic [DATA_W-1:0] portCIn,
  output logic [DATA_W-1:0] latA,
  output logic [DATA_W-1:0] latB,
  output logic [DATA_W-1:0] latC,
  output logic [DATA_W-1:0] oeA,
  output logic [DATA_W-1:0] oeB,
  output logic [DATA_W-1:0] oeC,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] viewA, viewB, viewC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latA <= '0;
      latB <= '0;
      latC <= '0;
    end else if (strobe.clrAll) begin
      latA <= '0;
      latB <= '0;
      latC <= '0;
    end else begin
      if (strobe.wrA) latA <= wrData;
      if (strobe.wrB) latB <= wrData;
      if (strobe.wrC) latC <= wrData;
      if (strobe.bitOp) latC[strobe.bitIdx] <= strobe.bitVal;
    end
  end

  assign oeA = {DATA_W{!dir.inA}};
  assign oeB = {DATA_W{!dir.inB}};
  assign viewA = dir.inA ? portAIn : latA;
  assign viewB = dir.inB ? portBIn : latB;

  for (genvar n = 0; n < 2; n++) begin : g_cNib
    logic nibIn;
    assign nibIn = (n == 1) ? dir.inCu : dir.inCl;
    assign oeC[n*NIB_W +: NIB_W]   = {NIB_W{!nibIn}};
    assign viewC[n*NIB_W +: NIB_W] = nibIn ? portCIn[n*NIB_W +: NIB_W]
                                           : latC[n*NIB_W +: NIB_W];
  end

  always_comb begin
    rdData = '0;
    if (!csN && !rdN) begin
      unique case (addr)
        2'd0:    rdData = viewA;
        2'd1:    rdData = viewB;
        2'd2:    rdData = viewC;
        default: rdData = '1;
      endcase
    end
  end
endmodule

// File: rtl/parPortCtl.sv
module parPortCtl
  import parPortPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] portAIn,
  output logic [DATA_W-1:0] portAOut,
  output logic [DATA_W-1:0] portAOe,
  input  logic [DATA_W-1:0] portBIn,
  output logic [DATA_W-1:0] portBOut,
  output logic [DATA_W-1:0] portBOe,
  input  logic [DATA_W-1:0] portCIn,
  output logic [DATA_W-1:0] portCOut,
  output logic [DATA_W-1:0] portCOe
);
  portStrobe_t strobe;
  portDir_t    dir;

  parPortCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .addr(addr),
    .wrData(wrData), .strobe(strobe), .dir(dir)
  );

  parPortData u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dir(dir), .csN(csN),
    .rdN(rdN), .addr(addr), .wrData(wrData), .portAIn(portAIn),
    .portBIn(portBIn), .portCIn(portCIn), .latA(portAOut),
    .latB(portBOut), .latC(portCOut), .oeA(portAOe), .oeB(portBOe),
    .oeC(portCOe), .rdData(rdData)
  );
endmodule

// File: rtl/parPortCtl_chk.sv
module parPortCtl_chk
  import parPortPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              rdN,
  input logic              wrN,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] portAOut,
  input logic [DATA_W-1:0] portAOe,
  input logic [DATA_W-1:0] portBOut,
  input logic [DATA_W-1:0] portBOe,
  input logic [DATA_W-1:0] portCOut,
  input logic [DATA_W-1:0] portCOe
);
  logic ctrlWr;
  assign ctrlWr = !csN && !wrN && (addr == 2'd3);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (portAOe == '0 && portBOe == '0 && portCOe == '0 &&
               portAOut == '0 && portBOut == '0 && portCOut == '0));

  a_r2_ctrl_reads_ff: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rdN && addr == 2'd3) |-> rdData == 8'hFF);

  a_r4_mode_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && wrData[7] && wrData[6:5] == 2'b00 && !wrData[2]) |=>
    (portAOut == '0 && portBOut == '0 && portCOut == '0));

  a_r5_reserved_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && wrData[7] && (wrData[6:5] != 2'b00 || wrData[2])) |=>
    ($stable(portAOe) && $stable(portBOe) && $stable(portCOe) &&
     $stable(portAOut) && $stable(portBOut) && $stable(portCOut)));

  a_r6_bit_loaded: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !wrData[7]) |=> portCOut[$past(wrData[3:1])] == $past(wrData[0]));

  a_r7_bit_keeps_dir: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !wrData[7]) |=>
    ($stable(portAOe) && $stable(portBOe) && $stable(portCOe)));

  a_r11_idle_bus_zero: assert property (@(posedge clk) disable iff (!rstN)
    (csN || rdN) |-> rdData == '0);

  a_r11_deselected_write: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> ($stable(portAOut) && $stable(portBOut) && $stable(portCOut) &&
             $stable(portAOe) && $stable(portBOe) && $stable(portCOe)));
endmodule

bind parPortCtl parPortCtl_chk u_chk (.*);

// File: tb/parPortCtl_tb.sv
module parPortCtl_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [7:0] portAIn = '0, portBIn = '0, portCIn = '0;
  logic [7:0] portAOut, portAOe, portBOut, portBOe, portCOut, portCOe;

  int vectors = 0;
  int errors  = 0;

  logic mInA, mInB, mInCu, mInCl;
  logic [7:0] mA, mB, mC;

  always #2.5 clk = ~clk;

  parPortCtl u_dut (.*);

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return mInA ? portAIn : mA;
      2'd1: return mInB ? portBIn : mB;
      2'd2: return {mInCu ? portCIn[7:4] : mC[7:4], mInCl ? portCIn[3:0] : mC[3:0]};
      default: return 8'hFF;
    endcase
  endfunction

  task automatic modelWrite(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'd0: mA = d;
      2'd1: mB = d;
      2'd2: mC = d;
      default: begin
        if (d[7]) begin
          if (d[6:5] == 2'b00 && !d[2]) begin
            mInA = d[4]; mInCu = d[3]; mInB = d[1]; mInCl = d[0];
            mA = '0; mB = '0; mC = '0;
          end
        end else begin
          mC[d[3:1]] = d[0];
        end
      end
    endcase
  endtask

  task automatic checkPins(input string req);
    chk({req, " A out"}, portAOut, mA);
    chk({req, " B out"}, portBOut, mB);
    chk({req, " C out"}, portCOut, mC);
    chk({req, " A oe"}, portAOe, {8{!mInA}});
    chk({req, " B oe"}, portBOe, {8{!mInB}});
    chk({req, " C oe"}, portCOe, {{4{!mInCu}}, {4{!mInCl}}});
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk);
    addr = a; wrData = d; csN = !sel; wrN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    csN = 1'b1; wrN = 1'b1;
    if (sel) modelWrite(a, d);
  endtask

  task automatic busRead(input logic [1:0] a, input string req);
    @(negedge clk);
    addr = a; csN = 1'b0; rdN = 1'b0;
    #1;
    chk(req, rdData, expRead(a));
    csN = 1'b1; rdN = 1'b1;
    #1;
    chk("R11 idle bus", rdData, 8'h00);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    mInA = 1; mInB = 1; mInCu = 1; mInCl = 1; mA = 0; mB = 0; mC = 0;
    repeat (3) @(negedge clk);
    checkPins("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkPins("R1 after reset");

    portAIn = 8'hA5; portBIn = 8'h3C; portCIn = 8'hE1;
    busRead(2'd0, "R8 A input pins");
    busRead(2'd2, "R9 C input pins");
    busRead(2'd3, "R2 ctrl reads FF");

    busWrite(2'd3, 8'h80, 1'b1);
    checkPins("R3 all outputs");
    busWrite(2'd0, 8'h5A, 1'b1);
    busWrite(2'd1, 8'hC3, 1'b1);
    busWrite(2'd2, 8'h0F, 1'b1);
    checkPins("R10 latch writes");
    busRead(2'd1, "R8 B output latch");

    busWrite(2'd3, 8'h09, 1'b1);
    checkPins("R6 0x09 sets C4");
    chk("R6 C4 value", portCOut, 8'h1F);
    busWrite(2'd3, 8'h70, 1'b1);
    checkPins("R6 R7 clear C0, dir kept");

    busWrite(2'd3, 8'hA0, 1'b1);
    checkPins("R5 reserved group A mode");
    busWrite(2'd3, 8'h84, 1'b1);
    checkPins("R5 reserved group B mode");

    busWrite(2'd0, 8'hFF, 1'b0);
    checkPins("R11 deselected write");

    busWrite(2'd3, 8'h88, 1'b1);
    checkPins("R3 R4 C upper input");
    busWrite(2'd2, 8'h96, 1'b1);
    busRead(2'd2, "R9 mixed nibbles");

    busWrite(2'd3, 8'h9B, 1'b1);
    checkPins("R3 0x9B all inputs");

    for (int i = 0; i < 400; i++) begin
      logic [7:0] d;
      logic [1:0] a;
      d = 8'($urandom);
      a = 2'($urandom);
      portAIn = 8'($urandom); portBIn = 8'($urandom); portCIn = 8'($urandom);
      if ($urandom % 3 == 0) begin
        busRead(a, "R8 R9 random read");
      end else begin
        if (a == 2'd3 && d[7] && ($urandom % 4 != 0)) d = d & 8'h9B;
        busWrite(a, d, ($urandom % 8) != 0);
        checkPins("R3 R4 R5 R6 R10 random write");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule